// File: doc/BRIEF.md
# Packet DMA Channel Register Front End

This block is the register front end for one channel of a two-channel packet DMA disk controller. A simple byte-addressed register bus writes 16-bit values into the channel's control word, its descriptor count, its 32-bit next-descriptor pointer (written as two halves) and its input and output FIFO thresholds. The same bus reads these values back one cycle later. The bus also reads an 8-bit status word, which holds sticky event flags reported by the packet engine and clears itself when read.

Setting the start bit in the control word produces a one-cycle launch pulse for the packet engine. That pulse appears only after a chip-wide enable register has been written with its key value, and only when no packet is already in flight. A separate reset bit in the control word holds the engine idle for as long as it stays set. The channel's interrupt line is the OR of the latched status flags, blocked by a mask bit.

Top module: `pdma_chan_regs`

## Requirements
- R1: The channel bank starts at byte address 0x80 + CHAN_IDX*0x20. Within the bank, the offsets are: control 0x0, status 0x2, descriptor count 0x4, next-pointer low half 0xC, next-pointer high half 0xE, input threshold 0x14, output threshold 0x16. A read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd`. Unmapped addresses, including other channels' banks, read as 0 and change nothing.
- R2: Control word fields are bit 8 interrupt mask (1 = masked), bit 7 start, bit 5 engine reset, and bits 1:0 transfer mode, which drives `xfer_mode`. Reading the control word returns the mask, reset and mode fields; the start bit always reads 0.
- R3: A write at byte address 0xC7 whose low byte equals 7 sets the go enable, and it stays set until reset. Writes with any other value leave it unchanged. While go enable is clear, start writes are ignored.
- R4: An accepted start write raises `go_pulse` for exactly one cycle, in the cycle after the write, and sets `pkt_active`.
- R5: A start write while `pkt_active` is high produces no pulse.
- R6: A control write with bit 7 clear drops `pkt_active` (register mode). A `pkt_done` pulse also drops it.
- R7: A control write with bit 5 set does the following: it raises `eng_reset`, aborts the active packet and clears status. While `eng_reset` stays high, start bits and engine events are ignored. It stays high until a control write with bit 5 clear.
- R8: Status bit 0 latches `ev_perr`, bit 6 latches `ev_psd` and bit 4 latches `ev_uirq`. A status read returns the latched bits and clears them. An event in the same cycle as the read is returned by the next read.
- R9: `irq` is high when any status bit is set and the control mask bit is 0.
- R10: After reset, all registers, go enable, `pkt_active`, `go_pulse`, `eng_reset` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| ev_perr | input | 1 | Engine event: bus parity error |
| ev_psd | input | 1 | Engine event: abnormal packet completion |
| ev_uirq | input | 1 | Engine event: unexpected device interrupt |
| pkt_done | input | 1 | Engine reports the packet finished |
| go_pulse | output | 1 | One-cycle packet launch |
| pkt_active | output | 1 | A packet is in flight |
| eng_reset | output | 1 | Engine held in reset |
| xfer_mode | output | 2 | Transfer mode field |
| irq | output | 1 | Masked channel interrupt |
| cpb_count | output | DATA_W | Descriptor count |
| cpb_next | output | 2*DATA_W | Next descriptor pointer |
| fifo_in_thr | output | DATA_W | Input FIFO threshold |
| fifo_out_thr | output | DATA_W | Output FIFO threshold |

## Verification
The assertions check, on every cycle, the following properties. The launch pulse is one cycle wide, never fires without go enable and always comes with `pkt_active`. Go enable never falls. A start during an active packet is dropped. A held engine reset keeps the channel idle with empty status. A status read without a new event leaves status empty. Only the bench scenarios can show the rest: the address map, the key-value gating of the lock, and the ordering of a read that coincides with an event. The interaction of the mask with `irq` and the release of reset by a later control write also need the bench.

// File: rtl/pdma_chan_pkg.sv
// Package: shared register identifiers, offsets and bit positions for
// the packet DMA channel register front end.
// Assumes byte addressing and a 16-bit data path.
package pdma_chan_pkg;

    typedef enum logic [3:0] {
        RID_NONE,
        RID_CTRL,
        RID_STAT,
        RID_COUNT,
        RID_NEXT_LO,
        RID_NEXT_HI,
        RID_FIFO_IN,
        RID_FIFO_OUT,
        RID_LOCK
    } reg_id_e;

    localparam int unsigned OFS_CTRL     = 32'h00;
    localparam int unsigned OFS_STAT     = 32'h02;
    localparam int unsigned OFS_COUNT    = 32'h04;
    localparam int unsigned OFS_NEXT_LO  = 32'h0C;
    localparam int unsigned OFS_NEXT_HI  = 32'h0E;
    localparam int unsigned OFS_FIFO_IN  = 32'h14;
    localparam int unsigned OFS_FIFO_OUT = 32'h16;

    localparam int unsigned LOCK_ADDR = 32'hC7;
    localparam logic [7:0]  LOCK_KEY  = 8'h07;

    localparam int CB_MASK = 8;
    localparam int CB_GO   = 7;
    localparam int CB_RST  = 5;

    localparam int SB_PSD  = 6;
    localparam int SB_UIRQ = 4;
    localparam int SB_PERR = 0;

endpackage

// File: rtl/pdma_addr_decode.sv
// Address decoder: maps a byte address to the register it selects.
// It finds the channel's bank from BANK_BASE, BANK_STRIDE and CHAN_IDX,
// and also recognises the chip-wide go enable register.
// Assumes the go enable address lies outside every channel bank.
module pdma_addr_decode
    import pdma_chan_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int BANK_BASE   = 128,
    parameter int BANK_STRIDE = 32,
    parameter int CHAN_IDX    = 0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_id_e           id_o
);
    localparam int unsigned BANK_LO = BANK_BASE + CHAN_IDX * BANK_STRIDE;
    localparam int unsigned BANK_HI = BANK_LO + BANK_STRIDE;

    logic [31:0] a32;
    logic [31:0] ofs;

    assign a32 = 32'(addr_i);
    assign ofs = a32 - BANK_LO;

    // Select the register addressed, or none.
    always_comb begin
        id_o = RID_NONE;
        if (a32 == LOCK_ADDR) begin
            id_o = RID_LOCK;
        end else if (a32 >= BANK_LO && a32 < BANK_HI) begin
            case (ofs)
                OFS_CTRL:     id_o = RID_CTRL;
                OFS_STAT:     id_o = RID_STAT;
                OFS_COUNT:    id_o = RID_COUNT;
                OFS_NEXT_LO:  id_o = RID_NEXT_LO;
                OFS_NEXT_HI:  id_o = RID_NEXT_HI;
                OFS_FIFO_IN:  id_o = RID_FIFO_IN;
                OFS_FIFO_OUT: id_o = RID_FIFO_OUT;
                default:      id_o = RID_NONE;
            endcase
        end
    end

endmodule

// File: rtl/pdma_go_ctrl.sv
// Launch control: holds the sticky go enable and the packet-active flag,
// and produces the one-cycle launch pulse.
// Assumes the control write strobe is already decoded for this channel.
module pdma_go_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr_i,
    input  logic       wgo_i,
    input  logic       wrst_i,
    input  logic       lock_wr_i,
    input  logic [7:0] lock_data_i,
    input  logic       done_i,
    output logic       go_pulse_o,
    output logic       active_o,
    output logic       lock_o
);
    import pdma_chan_pkg::*;

    logic lock_q;
    logic active_q;
    logic pulse_q;
    logic go_ok;

    // A start is accepted only when enabled, idle and not resetting.
    assign go_ok = ctrl_wr_i & wgo_i & ~wrst_i & lock_q & ~active_q;

    // Go enable: set by the key value, never cleared except by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 1'b0;
        else if (lock_wr_i && lock_data_i == LOCK_KEY)
            lock_q <= 1'b1;
    end

    // Packet-active flag and the launch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            pulse_q <= go_ok;
            if (ctrl_wr_i && (wrst_i || !wgo_i))
                active_q <= 1'b0;
            else if (go_ok)
                active_q <= 1'b1;
            else if (done_i)
                active_q <= 1'b0;
        end
    end

    assign go_pulse_o = pulse_q;
    assign active_o   = active_q;
    assign lock_o     = lock_q;

    p_go_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
    p_go_sets_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> active_q);
    p_go_needs_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> lock_q);
    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    p_no_go_when_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && active_q) |=> !pulse_q);

endmodule

// File: rtl/pdma_stat_latch.sv
// Status latch: collects engine event flags into sticky bits.
// A read clears the bits; an event in the read cycle survives the clear.
// Drives the masked interrupt. Assumes hold_i covers engine reset.
module pdma_stat_latch #(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] ev_i,
    input  logic              hold_i,
    input  logic              rd_clr_i,
    input  logic              mask_i,
    output logic [STAT_W-1:0] stat_o,
    output logic              irq_o
);
    logic [STAT_W-1:0] stat_q;

    // Sticky event capture with clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i)
            stat_q <= '0;
        else if (rd_clr_i)
            stat_q <= ev_i;
        else
            stat_q <= stat_q | ev_i;
    end

    assign stat_o = stat_q;
    assign irq_o  = (|stat_q) & ~mask_i;

    p_rd_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !hold_i && ev_i == '0) |=> stat_q == '0);
    p_ev_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0 && !hold_i) |=> stat_q != '0);

endmodule

// File: rtl/pdma_chan_regs.sv
// Top: register front end of one packet DMA channel. It holds the
// control, count, pointer and threshold registers and returns read data
// one cycle after a read strobe. It joins the decoder, the launch
// control and the status latch. Assumes a single-cycle register bus.
module pdma_chan_regs
    import pdma_chan_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int STAT_W      = 8,
    parameter int BANK_BASE   = 128,
    parameter int BANK_STRIDE = 32,
    parameter int CHAN_IDX    = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    input  logic                ev_perr,
    input  logic                ev_psd,
    input  logic                ev_uirq,
    input  logic                pkt_done,
    output logic                go_pulse,
    output logic                pkt_active,
    output logic                eng_reset,
    output logic [1:0]          xfer_mode,
    output logic                irq,
    output logic [DATA_W-1:0]   cpb_count,
    output logic [2*DATA_W-1:0] cpb_next,
    output logic [DATA_W-1:0]   fifo_in_thr,
    output logic [DATA_W-1:0]   fifo_out_thr
);
    localparam int PTR_W = 2 * DATA_W;

    reg_id_e           rid;
    logic              ctrl_wr;
    logic              mask_q;
    logic              rst_q;
    logic [1:0]        mode_q;
    logic [DATA_W-1:0] count_q;
    logic [PTR_W-1:0]  next_q;
    logic [DATA_W-1:0] fin_q;
    logic [DATA_W-1:0] fout_q;
    logic [STAT_W-1:0] ev_vec;
    logic [STAT_W-1:0] stat_w;
    logic              hold;
    logic              lock_w;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    pdma_addr_decode #(
        .ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE),
        .BANK_STRIDE(BANK_STRIDE), .CHAN_IDX(CHAN_IDX)
    ) u_dec (
        .addr_i(bus_addr),
        .id_o  (rid)
    );

    assign ctrl_wr = bus_wr && rid == RID_CTRL;

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= 1'b0;
            rst_q   <= 1'b0;
            mode_q  <= 2'b00;
            count_q <= '0;
            next_q  <= '0;
            fin_q   <= '0;
            fout_q  <= '0;
        end else if (bus_wr) begin
            case (rid)
                RID_CTRL: begin
                    mask_q <= bus_wdata[CB_MASK];
                    rst_q  <= bus_wdata[CB_RST];
                    mode_q <= bus_wdata[1:0];
                end
                RID_COUNT:    count_q <= bus_wdata;
                RID_NEXT_LO:  next_q[DATA_W-1:0] <= bus_wdata;
                RID_NEXT_HI:  next_q[PTR_W-1:DATA_W] <= bus_wdata;
                RID_FIFO_IN:  fin_q <= bus_wdata;
                RID_FIFO_OUT: fout_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    pdma_go_ctrl u_go (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr_i  (ctrl_wr),
        .wgo_i      (bus_wdata[CB_GO]),
        .wrst_i     (bus_wdata[CB_RST]),
        .lock_wr_i  (bus_wr && rid == RID_LOCK),
        .lock_data_i(bus_wdata[7:0]),
        .done_i     (pkt_done),
        .go_pulse_o (go_pulse),
        .active_o   (pkt_active),
        .lock_o     (lock_w)
    );

    // Place engine events at their status bit positions.
    always_comb begin
        ev_vec          = '0;
        ev_vec[SB_PERR] = ev_perr;
        ev_vec[SB_UIRQ] = ev_uirq;
        ev_vec[SB_PSD]  = ev_psd;
    end

    assign hold = rst_q | (ctrl_wr & bus_wdata[CB_RST]);

    pdma_stat_latch #(.STAT_W(STAT_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    (ev_vec),
        .hold_i  (hold),
        .rd_clr_i(bus_rd && rid == RID_STAT),
        .mask_i  (mask_q),
        .stat_o  (stat_w),
        .irq_o   (irq)
    );

    // Read data selection from the current register values.
    always_comb begin
        rd_mux = '0;
        case (rid)
            RID_CTRL: begin
                rd_mux[CB_MASK] = mask_q;
                rd_mux[CB_RST]  = rst_q;
                rd_mux[1:0]     = mode_q;
            end
            RID_STAT:     rd_mux = DATA_W'(stat_w);
            RID_COUNT:    rd_mux = count_q;
            RID_NEXT_LO:  rd_mux = next_q[DATA_W-1:0];
            RID_NEXT_HI:  rd_mux = next_q[PTR_W-1:DATA_W];
            RID_FIFO_IN:  rd_mux = fin_q;
            RID_FIFO_OUT: rd_mux = fout_q;
            default:      rd_mux = '0;
        endcase
    end

    // Registered read return, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_rd;
            if (bus_rd)
                rdata_q <= rd_mux;
        end
    end

    assign bus_rdata    = rdata_q;
    assign bus_rvalid   = rvalid_q;
    assign eng_reset    = rst_q;
    assign xfer_mode    = mode_q;
    assign cpb_count    = count_q;
    assign cpb_next     = next_q;
    assign fifo_in_thr  = fin_q;
    assign fifo_out_thr = fout_q;

    p_rst_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |-> (!pkt_active && stat_w == '0 && !go_pulse));
    p_rst_blocks_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[CB_RST]) |=> !go_pulse);
    p_go_after_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        go_pulse |-> lock_w);

endmodule

// File: tb/sim_pdma_chan_regs.sv
module sim_pdma_chan_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic        ev_perr = 1'b0, ev_psd = 1'b0, ev_uirq = 1'b0, pkt_done = 1'b0;
    logic        go_pulse, pkt_active, eng_reset, irq;
    logic [1:0]  xfer_mode;
    logic [15:0] cpb_count, fifo_in_thr, fifo_out_thr;
    logic [31:0] cpb_next;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    pdma_chan_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .ev_perr(ev_perr), .ev_psd(ev_psd),
        .ev_uirq(ev_uirq), .pkt_done(pkt_done), .go_pulse(go_pulse),
        .pkt_active(pkt_active), .eng_reset(eng_reset), .xfer_mode(xfer_mode),
        .irq(irq), .cpb_count(cpb_count), .cpb_next(cpb_next),
        .fifo_in_thr(fifo_in_thr), .fifo_out_thr(fifo_out_thr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: issue a read and queue its expected value.
    task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: ev_perr = 1'b1;
            1: ev_psd = 1'b1;
            2: ev_uirq = 1'b1;
            default: pkt_done = 1'b1;
        endcase
        @(negedge clk);
        ev_perr = 1'b0; ev_psd = 1'b0; ev_uirq = 1'b0; pkt_done = 1'b0;
    endtask

    // Monitor: compare returned read data against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_errors++;
                $display("FAIL R1: unexpected read data actual=%0h expected=none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), 32'(bus_rdata), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check("R10 go_pulse", 32'(go_pulse), 0);
        check("R10 pkt_active", 32'(pkt_active), 0);
        check("R10 eng_reset", 32'(eng_reset), 0);
        check("R10 irq", 32'(irq), 0);
        check("R10 cpb_next", cpb_next, 0);
        rd(8'h80, 16'h0000, "R10 ctrl read");
        rd(8'h82, 16'h0000, "R10 status read");

        // R1 map and readback
        wr(8'h84, 16'h0001);
        wr(8'h94, 16'h0100);
        wr(8'h96, 16'h0100);
        wr(8'h8C, 16'h1234);
        wr(8'h8E, 16'hABCD);
        check("R1 cpb_next", cpb_next, 32'hABCD1234);
        check("R1 fifo_in_thr", 32'(fifo_in_thr), 32'h0100);
        wr(8'hA4, 16'h7777);
        wr(8'h88, 16'h5555);
        rd(8'h84, 16'h0001, "R1 count unchanged by other bank");
        rd(8'h96, 16'h0100, "R1 out threshold");
        rd(8'h8E, 16'hABCD, "R1 next high");
        rd(8'h88, 16'h0000, "R1 unmapped reads 0");

        // R2 control fields
        wr(8'h80, 16'h0103);
        check("R2 xfer_mode", 32'(xfer_mode), 3);
        rd(8'h80, 16'h0103, "R2 ctrl readback");

        // R3 go before lock ignored, wrong key ignored
        wr(8'h80, 16'h0083);
        check("R3 no pulse before lock", 32'(go_pulse), 0);
        check("R3 not active before lock", 32'(pkt_active), 0);
        wr(8'hC7, 16'h0005);
        wr(8'h80, 16'h0083);
        check("R3 wrong key ignored", 32'(go_pulse), 0);
        wr(8'hC7, 16'h0007);
        wr(8'hC7, 16'h0000);
        wr(8'h80, 16'h0083);
        check("R4 pulse after go", 32'(go_pulse), 1);
        check("R4 active after go", 32'(pkt_active), 1);
        rd(8'h80, 16'h0003, "R2 start reads 0");
        check("R4 pulse one cycle", 32'(go_pulse), 0);

        // R5 go while active
        wr(8'h80, 16'h0083);
        check("R5 no pulse while active", 32'(go_pulse), 0);
        check("R5 still active", 32'(pkt_active), 1);

        // R6 register mode and done
        wr(8'h80, 16'h0003);
        check("R6 register mode ends packet", 32'(pkt_active), 0);
        wr(8'h80, 16'h0083);
        check("R6 relaunch", 32'(go_pulse), 1);
        pulse(3);
        check("R6 done ends packet", 32'(pkt_active), 0);

        // R8 / R9 status and interrupt
        pulse(0);
        check("R9 irq unmasked", 32'(irq), 1);
        rd(8'h82, 16'h0001, "R8 perr at bit 0");
        check("R8 irq after read clear", 32'(irq), 0);
        rd(8'h82, 16'h0000, "R8 cleared by read");
        pulse(1);
        pulse(2);
        rd(8'h82, 16'h0050, "R8 psd bit 6 uirq bit 4");
        wr(8'h80, 16'h0103);
        pulse(2);
        check("R9 irq masked", 32'(irq), 0);
        rd(8'h82, 16'h0010, "R8 masked event still latched");
        // event coinciding with a read
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 8'h82; ev_perr = 1'b1;
        exp_q.push_back(16'h0000); tag_q.push_back("R8 read with same-cycle event");
        @(negedge clk);
        bus_rd = 1'b0; ev_perr = 1'b0;
        rd(8'h82, 16'h0001, "R8 same-cycle event kept");

        // R7 engine reset
        wr(8'h80, 16'h0083);
        check("R7 precondition active", 32'(pkt_active), 1);
        wr(8'h80, 16'h0020);
        check("R7 eng_reset high", 32'(eng_reset), 1);
        check("R7 packet aborted", 32'(pkt_active), 0);
        pulse(0);
        check("R7 event ignored irq", 32'(irq), 0);
        rd(8'h82, 16'h0000, "R7 status held clear");
        rd(8'h80, 16'h0020, "R7 ctrl readback");
        wr(8'h80, 16'h00A3);
        check("R7 go with reset ignored", 32'(go_pulse), 0);
        wr(8'h80, 16'h0000);
        check("R7 released", 32'(eng_reset), 0);
        wr(8'h80, 16'h0083);
        check("R7 go after release", 32'(go_pulse), 1);

        repeat (4) @(negedge clk);
        check("R1 all reads returned", exp_q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule